// File: doc/BRIEF.md
# Per-CPU Interrupt Level Combiner

This block sits beside one processor and decides which of its fifteen interrupt levels are asserted. It holds a local pending word with three kinds of content. Software interrupts are raised and dropped by register writes. A processor-local timer input is level-sensitive. A level-15 input is edge-tracked and can also be cleared by software. The block merges this word with the hard-interrupt levels that the system controller routes to the processor currently chosen as the interrupt target. The result goes out as a registered level vector with one line per level.

Software uses a small word-addressed port. Word 0 returns the pending word. Word 1 clears selected bits and word 2 raises software interrupts. When this processor is the target, the pending word read back also shows the routed hard levels 1 to 13 as bits 13..1. Those bits are rebuilt from the inputs every cycle and are never stored.

Top module: `cpu_irl_combiner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `irl_out` and `rd_data` are zero and the stored pending word is empty.
- R2: `rd_data` is registered. One cycle after word address 0 is presented it holds the pending word as updated at that edge. Bits 31:17 are soft interrupts, bit 15 is the level-15 bit and bit 14 is the timer bit. When `tgt_sel` is high, bits 13..1 equal `hard_shown`. Every other address reads as zero.
- R3: A write to word 1 clears the pending bits that are set in `wr_data`, but only within bits 31:17 and bit 15. The timer bit and all other bits are unaffected.
- R4: A write to word 2 sets the pending bits that are set in `wr_data`, but only within bits 31:17. All other written bits are ignored.
- R5: Soft bit 17+k (k = 0..14) drives level 1+k on `irl_out`.
- R6: The pending timer bit 14 follows `timer_in` and drives level 14 whatever the other inputs are. Software writes cannot clear it.
- R7: A rising edge of `l15_in` sets bit 15 and a falling edge clears it. An edge wins over a clear write in the same cycle. Bit 15 drives level 15 unmasked.
- R8: `hard_act` levels reach `irl_out` only while `tgt_sel` is high. `hard_shown` appears in the read word only while `tgt_sel` is high and leaves no stored trace.
- R9: `irl_out[0]` is always zero. Every output change appears on the clock edge that samples the causing write or input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (2) | Word address for reads and writes |
| wr_data | input | 2*NLVL+2 (32) | Write data |
| rd_data | output | 2*NLVL+2 (32) | Registered read data |
| timer_in | input | 1 | Local timer request, level-sensitive |
| l15_in | input | 1 | Level-15 request, edge-tracked |
| tgt_sel | input | 1 | This processor is the hard-interrupt target |
| hard_act | input | NLVL (15:1) | Masked hard levels from the system controller |
| hard_shown | input | NLVL-2 (13:1) | Unmasked hard levels shown in the read word |
| irl_out | output | NLVL+1 (16) | Registered level vector, bit 0 always zero |

## Verification
The bench writes masks that reach into bits 16, 14 and 13:0. A design that ignored the per-word masks would then set or clear the timer or display bits through software. It drops `tgt_sel` while hard levels are active. A design that gated badly would leak hard levels or stored display bits into the output or the read word. It holds `l15_in` high, clears bit 15 by software, and then times an edge against a clear write in the same cycle. A design with the wrong priority, or one that treated the input as a level, would bring the bit back or lose it. Random traffic then compares every cycle against the reference model, which catches a design whose latency is off by one cycle.

// File: rtl/irl_comb_pkg.sv
package irl_comb_pkg;
  typedef enum logic [1:0] {
    OFF_PEND = 2'd0,
    OFF_CLR  = 2'd1,
    OFF_SET  = 2'd2,
    OFF_RSVD = 2'd3
  } reg_off_e;
endpackage

// File: rtl/irl_pend_reg.sv
module irl_pend_reg #(
  parameter int NLVL = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_clr,
  input  logic              do_set,
  input  logic [2*NLVL+1:0] wdata,
  input  logic              timer_in,
  input  logic              l15_in,
  output logic [2*NLVL+1:0] pend_nxt
);
  localparam int DW  = 2*NLVL + 2;
  localparam int TMR = NLVL - 1;
  localparam int L15 = NLVL;
  localparam logic [DW-1:0] SOFT_M = {{NLVL{1'b1}}, {(NLVL+2){1'b0}}};
  localparam logic [DW-1:0] CLR_M  = SOFT_M | (DW'(1) << L15);

  logic [DW-1:0] pend_q;
  logic          l15_q;

  always_comb begin
    pend_nxt = pend_q;
    if (do_clr) pend_nxt = pend_nxt & ~(wdata & CLR_M);
    if (do_set) pend_nxt = pend_nxt | (wdata & SOFT_M);
    // input edges are the later event and win over a software clear
    if (l15_in && !l15_q) pend_nxt[L15] = 1'b1;
    if (!l15_in && l15_q) pend_nxt[L15] = 1'b0;
    pend_nxt[TMR] = timer_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      l15_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      l15_q  <= l15_in;
    end
  end
endmodule

// File: rtl/irl_level_merge.sv
module irl_level_merge #(
  parameter int NLVL = 15
) (
  input  logic [2*NLVL+1:0] pend_nxt,
  input  logic              tgt_sel,
  input  logic [NLVL:1]     hard_act,
  output logic [NLVL:0]     lvl_nxt
);
  assign lvl_nxt[0] = 1'b0;

  for (genvar k = 1; k <= NLVL; k++) begin : g_lvl
    if (k >= NLVL - 1) begin : g_unmasked
      // timer and level-15 bits sit at their own level position
      assign lvl_nxt[k] = pend_nxt[k+NLVL+1] | pend_nxt[k] | (tgt_sel & hard_act[k]);
    end else begin : g_plain
      assign lvl_nxt[k] = pend_nxt[k+NLVL+1] | (tgt_sel & hard_act[k]);
    end
  end
endmodule

// File: rtl/irl_read_port.sv
module irl_read_port #(
  parameter int NLVL   = 15,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_pend,
  input  logic [2*NLVL+1:0] pend_nxt,
  input  logic              tgt_sel,
  input  logic [NLVL-2:1]   hard_shown,
  output logic [2*NLVL+1:0] rd_data
);
  localparam int DW = 2*NLVL + 2;

  logic [DW-1:0] disp;

  for (genvar b = 0; b < DW; b++) begin : g_disp
    if (b >= 1 && b <= NLVL - 2) begin : g_hard
      assign disp[b] = tgt_sel & hard_shown[b];
    end else begin : g_zero
      assign disp[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rd_data <= '0;
    else if (sel_pend) rd_data <= pend_nxt | disp;
    else               rd_data <= '0;
  end
endmodule

// File: rtl/cpu_irl_combiner.sv
module cpu_irl_combiner #(
  parameter int NLVL   = 15,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [2*NLVL+1:0] wr_data,
  output logic [2*NLVL+1:0] rd_data,
  input  logic              timer_in,
  input  logic              l15_in,
  input  logic              tgt_sel,
  input  logic [NLVL:1]     hard_act,
  input  logic [NLVL-2:1]   hard_shown,
  output logic [NLVL:0]     irl_out
);
  import irl_comb_pkg::*;

  localparam int DW = 2*NLVL + 2;

  logic          do_clr, do_set, sel_pend;
  logic [DW-1:0] pend_nxt;
  logic [NLVL:0] lvl_nxt;

  assign do_clr   = wr_en && (reg_addr == ADDR_W'(OFF_CLR));
  assign do_set   = wr_en && (reg_addr == ADDR_W'(OFF_SET));
  assign sel_pend = (reg_addr == ADDR_W'(OFF_PEND));

  irl_pend_reg #(.NLVL(NLVL)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .do_clr   (do_clr),
    .do_set   (do_set),
    .wdata    (wr_data),
    .timer_in (timer_in),
    .l15_in   (l15_in),
    .pend_nxt (pend_nxt)
  );

  irl_level_merge #(.NLVL(NLVL)) u_merge (
    .pend_nxt (pend_nxt),
    .tgt_sel  (tgt_sel),
    .hard_act (hard_act),
    .lvl_nxt  (lvl_nxt)
  );

  irl_read_port #(.NLVL(NLVL), .ADDR_W(ADDR_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .sel_pend   (sel_pend),
    .pend_nxt   (pend_nxt),
    .tgt_sel    (tgt_sel),
    .hard_shown (hard_shown),
    .rd_data    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) irl_out <= '0;
    else     irl_out <= lvl_nxt;
  end
endmodule

// File: rtl/irl_comb_chk.sv
module irl_comb_chk #(
  parameter int NLVL   = 15,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [2*NLVL+1:0] wr_data,
  input logic [2*NLVL+1:0] rd_data,
  input logic              timer_in,
  input logic [NLVL:0]     irl_out
);
  logic rst_seen = 1'b0;

  always @(posedge clk) begin
    if (rst_seen) begin
      AST_RESET_QUIET: assert (irl_out == '0 && rd_data == '0); // R1
    end
    rst_seen <= rst;
  end

  AST_LVL0_LOW: assert property (@(posedge clk) disable iff (rst)
    irl_out[0] == 1'b0); // R9

  AST_TIMER_LEVEL: assert property (@(posedge clk) disable iff (rst)
    timer_in |=> irl_out[NLVL-1]); // R6

  AST_SET_TOP_SOFT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_addr == ADDR_W'(2) && wr_data[2*NLVL+1]) |=> irl_out[NLVL]); // R4

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr != '0) |=> (rd_data == '0)); // R2
endmodule

bind cpu_irl_combiner irl_comb_chk #(.NLVL(NLVL), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .reg_addr (reg_addr),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .timer_in (timer_in),
  .irl_out  (irl_out)
);

// File: tb/cpu_irl_combiner_tb.sv
module cpu_irl_combiner_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        timer_in = 1'b0;
  logic        l15_in = 1'b0;
  logic        tgt_sel = 1'b0;
  logic [15:1] hard_act = '0;
  logic [13:1] hard_shown = '0;
  logic [15:0] irl_out;

  int n_chk = 0;
  int n_fail = 0;

  // reference state
  logic [31:0] m_soft = '0;
  logic        m_b15 = 1'b0, m_b14 = 1'b0, m_prev15 = 1'b0;
  logic [31:0] e_rd = '0;
  logic [15:0] e_irl = '0;

  always #2.5 clk = ~clk;

  cpu_irl_combiner u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .timer_in(timer_in), .l15_in(l15_in), .tgt_sel(tgt_sel),
    .hard_act(hard_act), .hard_shown(hard_shown), .irl_out(irl_out)
  );

  task automatic model_edge();
    logic [31:0] view;
    if (rst) begin
      m_soft = '0; m_b15 = 1'b0; m_b14 = 1'b0; m_prev15 = 1'b0;
      e_rd = '0; e_irl = '0;
      return;
    end
    if (wr_en && reg_addr == 2'd1) begin
      m_soft = m_soft & ~(wr_data & 32'hFFFE_0000);
      if (wr_data[15]) m_b15 = 1'b0;
    end
    if (wr_en && reg_addr == 2'd2) m_soft = m_soft | (wr_data & 32'hFFFE_0000);
    if (l15_in && !m_prev15) m_b15 = 1'b1;
    if (!l15_in && m_prev15) m_b15 = 1'b0;
    m_prev15 = l15_in;
    m_b14 = timer_in;
    view = m_soft;
    view[15] = m_b15;
    view[14] = m_b14;
    if (tgt_sel) view[13:1] = hard_shown;
    e_rd = (reg_addr == 2'd0) ? view : 32'd0;
    e_irl = m_soft[31:16];
    e_irl[0] = 1'b0;
    e_irl[15] = e_irl[15] | m_b15;
    e_irl[14] = e_irl[14] | m_b14;
    if (tgt_sel) e_irl[15:1] = e_irl[15:1] | hard_act;
  endtask

  task automatic step(input string tag);
    model_edge();
    @(posedge clk);
    #1;
    n_chk++;
    if (rd_data !== e_rd) begin
      n_fail++;
      $display("FAIL %s rd_data actual %h expected %h", tag, rd_data, e_rd);
    end
    n_chk++;
    if (irl_out !== e_irl) begin
      n_fail++;
      $display("FAIL %s irl_out actual %h expected %h", tag, irl_out, e_irl);
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    step(tag);
    wr_en = 1'b0; reg_addr = 2'd0; wr_data = '0;
    step(tag);
  endtask

  initial begin
    @(negedge clk);
    step("R1 reset");
    step("R1 reset");
    rst = 1'b0;
    step("R1 first cycle");
    // set with stray bits: only 31:17 take
    wr(2'd2, 32'hFFFF_FFFF, "R4 set mask");
    wr(2'd1, 32'hAAAA_0000, "R3 clear soft");
    wr(2'd1, 32'hFFFF_FFFF, "R3 clear all");
    wr(2'd2, 32'h0002_0000, "R5 bit17 level1");
    wr(2'd2, 32'h8000_0000, "R5 bit31 level15");
    wr(2'd1, 32'hFFFE_0000, "R5 cleanup");
    // timer survives a full clear
    timer_in = 1'b1;
    step("R6 timer on");
    wr(2'd1, 32'hFFFF_FFFF, "R6 clear ignored");
    timer_in = 1'b0;
    step("R6 timer off");
    // level-15 input edges and software clear
    l15_in = 1'b1;
    step("R7 rise");
    wr(2'd1, 32'h0000_8000, "R7 sw clear");
    step("R7 held no re-set");
    l15_in = 1'b0;
    step("R7 fall");
    l15_in = 1'b1; wr_en = 1'b1; reg_addr = 2'd1; wr_data = 32'h0000_8000;
    step("R7 edge beats clear");
    wr_en = 1'b0; reg_addr = 2'd0; wr_data = '0;
    l15_in = 1'b0;
    step("R7 fall again");
    // target gating
    hard_act = 15'h1234; hard_shown = 13'h0AAA;
    step("R8 not target");
    tgt_sel = 1'b1;
    step("R8 target");
    reg_addr = 2'd3;
    step("R2 reserved read");
    reg_addr = 2'd1;
    step("R2 clear word read");
    reg_addr = 2'd0; tgt_sel = 1'b0;
    step("R8 display gone");
    hard_act = '0; hard_shown = '0;
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      wr_en = ($urandom_range(0, 2) == 0);
      reg_addr = 2'($urandom_range(0, 3));
      wr_data = $urandom();
      timer_in = ($urandom_range(0, 3) == 0);
      l15_in = ($urandom_range(0, 4) == 0) ? ~l15_in : l15_in;
      tgt_sel = ($urandom_range(0, 1) == 0);
      hard_act = 15'($urandom());
      hard_shown = 13'($urandom());
      step("R9 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule